// File: doc/BRIEF.md
# Serial Time-Slot Switch with Connection Memory

The block switches eight serial input streams onto eight serial output streams. Each stream runs one bit per clock. A frame holds 32 channels of 8 bits, sent most significant bit first, so a frame is 256 clocks long. A frame pulse on `fsync_i` marks the first bit of channel 0. Every input byte is captured into a two-bank data store, and each output slot is served from the bank that holds the previous complete frame.

Each output slot (output stream, channel) has a connection word made of a low byte and a high byte. Software writes these words through a simple write port, and reset clears them. The high byte selects one of two sources for the slot. One source is a byte from the data store: the input stream comes from the high byte and the input channel from the low byte. The other source is the low byte itself, sent as a message. The high byte also holds a per-slot drive enable and a control-stream bit. Two global inputs act over every slot. `msg_all_i` puts every slot into message mode with its driver on. `ode_i` low turns every driver off. A separate serial output, `ctl_out`, carries each slot's control bit one channel ahead of that slot.

Frame timing is kept by a two-state machine. It starts in HUNT. In HUNT all outputs are silent and no data is captured. The transition HUNT→RUN is taken on the first frame pulse. In RUN the machine stays in RUN: a bit counter wraps every 256 clocks, and any later frame pulse restarts the counter at position 0. Reset returns the machine to HUNT from either state.

Top module: `tsi_switch`

## Requirements
- R1: After a synchronous reset (`rst` high), `ser_oe`, `ser_out` and `ctl_out` are all 0, and every connection word is cleared to zero, so no slot drives until it is written again.
- R2: While no frame pulse has been seen since reset (state HUNT), `ser_oe`, `ser_out` and `ctl_out` stay 0, whatever `ode_i` and `msg_all_i` hold.
- R3: When high byte bit 2 is 0 and `msg_all_i` is 0, the slot carries the byte received in the previous frame on input stream high[7:5], channel low[4:0].
- R4: When high byte bit 2 is 1, the slot carries the 8-bit low byte of its connection word in every frame.
- R5: When `msg_all_i` is 1, every slot behaves as if its high byte bits 2 and 0 were both 1.
- R6: When `ode_i` is 0, every `ser_oe` bit is 0 and every `ser_out` bit is 0, overriding R5 and R7.
- R7: When `ode_i` is 1 and `msg_all_i` is 0, `ser_oe` for a slot follows high byte bit 0 of its connection word. A disabled slot outputs 0.
- R8: `ctl_out` sends high byte bit 1 of the slot (stream s, channel c) at frame position 8·((c−1) mod 32) + s.
- R9: Frame position p is 0 in the clock where `fsync_i` is 1 and counts one per clock after that. Position p is channel p/8, bit 7 − (p mod 8). The input bit of position p is sampled in that clock. The `ser_out`, `ser_oe` and `ctl_out` values for position p appear after that clock's rising edge. A connection word written with `cfg_we` (`cfg_hi` 1 = high byte, 0 = low byte, `cfg_addr` = {stream[2:0], channel[4:0]}) takes effect from the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; one serial bit per cycle |
| rst | input | 1 | Synchronous reset, active high |
| fsync_i | input | 1 | Frame pulse, high during position 0 |
| ser_in | input | 8 | Serial input bit of each input stream |
| ode_i | input | 1 | Global output drive enable |
| msg_all_i | input | 1 | Forces message mode and drive enable on all slots |
| cfg_we | input | 1 | Connection word write strobe |
| cfg_hi | input | 1 | 1 selects the high byte, 0 the low byte |
| cfg_addr | input | 8 | Slot address {output stream, channel} |
| cfg_wdata | input | 8 | Byte to write |
| ser_out | output | 8 | Serial output bit of each output stream |
| ser_oe | output | 8 | Driver enable of each output stream, registered with the bit |
| ctl_out | output | 1 | Serial control stream, one channel ahead |

## Verification
All three serial results for frame position p are due one clock after the clock that carries position p. The bench drives each position at a falling edge and samples 1 ns after the next rising edge, so each sample belongs to exactly that position. Switched data is due one whole frame after its input: the bench changes the input pattern in every frame and predicts the output from the frame before. Connection writes land at positions 0 and 1, and the channels under check start at position 16 or later. The control bit for channel c is sampled at the position given in R8, which falls inside channel c−1.

// File: rtl/tsi_switch_pkg.sv
package tsi_switch_pkg;

    localparam int SLOT_BITS   = 8;
    localparam int OFS_W       = 3;

    localparam int CMH_OE      = 0;
    localparam int CMH_CTL     = 1;
    localparam int CMH_MSG     = 2;
    localparam int CMH_SRC_LSB = 5;

    typedef enum logic {
        ST_HUNT = 1'b0,
        ST_RUN  = 1'b1
    } sync_state_e;

endpackage

// File: rtl/tsi_frame_timer.sv
module tsi_frame_timer
    import tsi_switch_pkg::*;
#(
    parameter int N_CHANNELS = 32,
    localparam int PW = $clog2(N_CHANNELS) + OFS_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fsync_i,
    output logic          active,
    output logic [PW-1:0] pos
);

    localparam int FRAME_BITS = N_CHANNELS * SLOT_BITS;
    localparam logic [PW-1:0] LAST_POS = PW'(FRAME_BITS - 1);

    sync_state_e   state_q, state_d;
    logic [PW-1:0] cnt_q;

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HUNT: if (fsync_i) state_d = ST_RUN;
            ST_RUN:  state_d = ST_RUN;
        endcase
    end

    // outputs
    always_comb begin
        active = (state_q == ST_RUN) || fsync_i;
        pos    = fsync_i ? '0 : cnt_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_HUNT;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (active)
                cnt_q <= (pos == LAST_POS) ? '0 : pos + 1'b1;
        end
    end

    assert_pulse_enters_run_R9: assert property (@(posedge clk) disable iff (rst)
        fsync_i |=> (state_q == ST_RUN));

    assert_count_steps_R9: assert property (@(posedge clk) disable iff (rst)
        (active && !fsync_i && pos != LAST_POS) |=> (fsync_i || pos == $past(pos) + 1'b1));

endmodule

// File: rtl/tsi_data_store.sv
module tsi_data_store
    import tsi_switch_pkg::*;
#(
    parameter int N_STREAMS  = 8,
    parameter int N_CHANNELS = 32,
    localparam int SW = $clog2(N_STREAMS),
    localparam int CW = $clog2(N_CHANNELS),
    localparam int PW = CW + OFS_W,
    localparam int AW = SW + CW
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic                                 active,
    input  logic [PW-1:0]                        pos,
    input  logic [N_STREAMS-1:0]                 ser_in,
    input  logic [N_STREAMS-1:0][AW-1:0]         rd_addr,
    output logic [N_STREAMS-1:0][SLOT_BITS-1:0]  rd_byte
);

    localparam int DEPTH = 1 << AW;
    localparam logic [PW-1:0] LAST_POS = PW'(N_CHANNELS * SLOT_BITS - 1);

    logic [SLOT_BITS-1:0] mem [2][DEPTH];
    logic [N_STREAMS-1:0][SLOT_BITS-2:0] shf_q;
    logic                 wbank_q;
    logic                 slot_end;

    assign slot_end = active && (pos[OFS_W-1:0] == OFS_W'(SLOT_BITS - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            shf_q   <= '0;
            wbank_q <= 1'b0;
        end else if (active) begin
            for (int s = 0; s < N_STREAMS; s++)
                shf_q[s] <= {shf_q[s][SLOT_BITS-3:0], ser_in[s]};
            if (pos == LAST_POS)
                wbank_q <= ~wbank_q;
        end
    end

    always_ff @(posedge clk) begin
        if (slot_end) begin
            for (int s = 0; s < N_STREAMS; s++)
                mem[wbank_q][{SW'(s), pos[PW-1:OFS_W]}] <= {shf_q[s], ser_in[s]};
        end
    end

    always_comb begin
        for (int s = 0; s < N_STREAMS; s++)
            rd_byte[s] = mem[~wbank_q][rd_addr[s]];
    end

    assert_bank_swaps_at_frame_end_R3: assert property (@(posedge clk) disable iff (rst)
        (active && pos == LAST_POS) |=> (wbank_q != $past(wbank_q)));

    assert_bank_holds_mid_frame_R3: assert property (@(posedge clk) disable iff (rst)
        (active && pos != LAST_POS) |=> $stable(wbank_q));

endmodule

// File: rtl/tsi_conn_mem.sv
module tsi_conn_mem
    import tsi_switch_pkg::*;
#(
    parameter int N_STREAMS  = 8,
    parameter int N_CHANNELS = 32,
    localparam int AW = $clog2(N_STREAMS) + $clog2(N_CHANNELS)
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic                                 cfg_we,
    input  logic                                 cfg_hi,
    input  logic [AW-1:0]                        cfg_addr,
    input  logic [SLOT_BITS-1:0]                 cfg_wdata,
    input  logic [N_STREAMS-1:0][AW-1:0]         rd_addr,
    output logic [N_STREAMS-1:0][SLOT_BITS-1:0]  lo_word,
    output logic [N_STREAMS-1:0][SLOT_BITS-1:0]  hi_word,
    input  logic [AW-1:0]                        ctl_addr,
    output logic                                 ctl_bit
);

    localparam int DEPTH = 1 << AW;

    logic [SLOT_BITS-1:0] lo_mem [DEPTH];
    logic [SLOT_BITS-1:0] hi_mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                lo_mem[i] <= '0;
                hi_mem[i] <= '0;
            end
        end else if (cfg_we) begin
            if (cfg_hi) hi_mem[cfg_addr] <= cfg_wdata;
            else        lo_mem[cfg_addr] <= cfg_wdata;
        end
    end

    always_comb begin
        for (int s = 0; s < N_STREAMS; s++) begin
            lo_word[s] = lo_mem[rd_addr[s]];
            hi_word[s] = hi_mem[rd_addr[s]];
        end
        ctl_bit = hi_mem[ctl_addr][CMH_CTL];
    end

    assert_write_lands_R9: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_hi) |=> (hi_mem[$past(cfg_addr)] == $past(cfg_wdata)));

endmodule

// File: rtl/tsi_out_lane.sv
module tsi_out_lane
    import tsi_switch_pkg::*;
#(
    parameter int N_STREAMS  = 8,
    parameter int N_CHANNELS = 32,
    localparam int SW = $clog2(N_STREAMS),
    localparam int CW = $clog2(N_CHANNELS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 active,
    input  logic [OFS_W-1:0]     bit_ofs,
    input  logic                 ode_i,
    input  logic                 msg_all_i,
    input  logic [SLOT_BITS-1:0] lo_word,
    input  logic [SLOT_BITS-1:0] hi_word,
    output logic [SW+CW-1:0]     src_addr,
    input  logic [SLOT_BITS-1:0] src_byte,
    output logic                 ser_out,
    output logic                 ser_oe
);

    logic                 use_msg;
    logic                 drive;
    logic [SLOT_BITS-1:0] chosen;
    logic                 unused_hi_bits;

    assign unused_hi_bits = ^{hi_word[CMH_SRC_LSB-1:CMH_MSG+1], hi_word[CMH_CTL]};

    always_comb begin
        src_addr = {hi_word[CMH_SRC_LSB +: SW], lo_word[CW-1:0]};
        use_msg  = msg_all_i || hi_word[CMH_MSG];
        drive    = active && ode_i && (msg_all_i || hi_word[CMH_OE]);
        chosen   = use_msg ? lo_word : src_byte;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ser_oe  <= 1'b0;
            ser_out <= 1'b0;
        end else begin
            ser_oe  <= drive;
            ser_out <= drive && chosen[OFS_W'(SLOT_BITS - 1) - bit_ofs];
        end
    end

    assert_drive_off_without_ode_R6: assert property (@(posedge clk) disable iff (rst)
        !$past(ode_i) |-> !ser_oe);

    assert_quiet_when_off_R7: assert property (@(posedge clk) disable iff (rst)
        ser_out |-> ser_oe);

    assert_global_msg_drives_R5: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(msg_all_i && ode_i && active)) |-> ser_oe);

    assert_message_bit_R4: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(drive && hi_word[CMH_MSG]))
            |-> (ser_out == $past(lo_word[OFS_W'(SLOT_BITS - 1) - bit_ofs])));

endmodule

// File: rtl/tsi_switch.sv
module tsi_switch
    import tsi_switch_pkg::*;
#(
    parameter int N_STREAMS  = 8,
    parameter int N_CHANNELS = 32,
    localparam int SW = $clog2(N_STREAMS),
    localparam int CW = $clog2(N_CHANNELS),
    localparam int PW = CW + OFS_W,
    localparam int AW = SW + CW
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 fsync_i,
    input  logic [N_STREAMS-1:0] ser_in,
    input  logic                 ode_i,
    input  logic                 msg_all_i,
    input  logic                 cfg_we,
    input  logic                 cfg_hi,
    input  logic [AW-1:0]        cfg_addr,
    input  logic [SLOT_BITS-1:0] cfg_wdata,
    output logic [N_STREAMS-1:0] ser_out,
    output logic [N_STREAMS-1:0] ser_oe,
    output logic                 ctl_out
);

    logic                                active;
    logic [PW-1:0]                       pos;
    logic [CW-1:0]                       chan;
    logic [CW-1:0]                       next_chan;
    logic [N_STREAMS-1:0][AW-1:0]        slot_addr;
    logic [N_STREAMS-1:0][AW-1:0]        src_addr;
    logic [N_STREAMS-1:0][SLOT_BITS-1:0] lo_word;
    logic [N_STREAMS-1:0][SLOT_BITS-1:0] hi_word;
    logic [N_STREAMS-1:0][SLOT_BITS-1:0] src_byte;
    logic [AW-1:0]                       ctl_addr;
    logic                                ctl_bit;
    logic                                ctl_q;

    tsi_frame_timer #(.N_CHANNELS(N_CHANNELS)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .fsync_i (fsync_i),
        .active  (active),
        .pos     (pos)
    );

    always_comb begin
        chan      = pos[PW-1:OFS_W];
        next_chan = (chan == CW'(N_CHANNELS - 1)) ? '0 : chan + 1'b1;
        ctl_addr  = {SW'(pos[OFS_W-1:0]), next_chan};
        for (int s = 0; s < N_STREAMS; s++)
            slot_addr[s] = {SW'(s), chan};
    end

    tsi_data_store #(.N_STREAMS(N_STREAMS), .N_CHANNELS(N_CHANNELS)) u_store (
        .clk     (clk),
        .rst     (rst),
        .active  (active),
        .pos     (pos),
        .ser_in  (ser_in),
        .rd_addr (src_addr),
        .rd_byte (src_byte)
    );

    tsi_conn_mem #(.N_STREAMS(N_STREAMS), .N_CHANNELS(N_CHANNELS)) u_conn (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_hi    (cfg_hi),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .rd_addr   (slot_addr),
        .lo_word   (lo_word),
        .hi_word   (hi_word),
        .ctl_addr  (ctl_addr),
        .ctl_bit   (ctl_bit)
    );

    for (genvar g = 0; g < N_STREAMS; g++) begin : g_lane
        tsi_out_lane #(.N_STREAMS(N_STREAMS), .N_CHANNELS(N_CHANNELS)) u_lane (
            .clk       (clk),
            .rst       (rst),
            .active    (active),
            .bit_ofs   (pos[OFS_W-1:0]),
            .ode_i     (ode_i),
            .msg_all_i (msg_all_i),
            .lo_word   (lo_word[g]),
            .hi_word   (hi_word[g]),
            .src_addr  (src_addr[g]),
            .src_byte  (src_byte[g]),
            .ser_out   (ser_out[g]),
            .ser_oe    (ser_oe[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) ctl_q <= 1'b0;
        else     ctl_q <= active && ctl_bit;
    end

    assign ctl_out = ctl_q;

    assert_hunt_is_silent_R2: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && !$past(active)) |-> (ser_oe == '0 && ser_out == '0 && !ctl_out));

    assert_reset_clears_R1: assert property (@(posedge clk)
        $past(rst) |-> (ser_oe == '0 && !ctl_out));

endmodule

// File: tb/sim_tsi_switch.sv
`timescale 1ns/1ps
module sim_tsi_switch;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       fsync_i = 1'b0;
    logic [7:0] ser_in = '0;
    logic       ode_i = 1'b0;
    logic       msg_all_i = 1'b0;
    logic       cfg_we = 1'b0;
    logic       cfg_hi = 1'b0;
    logic [7:0] cfg_addr = '0;
    logic [7:0] cfg_wdata = '0;
    logic [7:0] ser_out;
    logic [7:0] ser_oe;
    logic       ctl_out;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #4 clk = ~clk;

    tsi_switch u0 (
        .clk(clk), .rst(rst), .fsync_i(fsync_i), .ser_in(ser_in),
        .ode_i(ode_i), .msg_all_i(msg_all_i), .cfg_we(cfg_we), .cfg_hi(cfg_hi),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .ser_out(ser_out), .ser_oe(ser_oe), .ctl_out(ctl_out)
    );

    typedef struct packed {
        logic [2:0] s;
        logic [4:0] c;
        logic [7:0] lo;
        logic [7:0] hi;
        logic       me;
        logic       ode;
        logic       exp_oe;
        logic       exp_msg;
    } vec_t;

    // high byte: [0] drive enable, [1] control bit, [2] message, [7:5] source stream
    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{3'd1, 5'd4,  8'h07, 8'h61, 1'b0, 1'b1, 1'b1, 1'b0},  // R3 switch from in 3 ch 7
        '{3'd2, 5'd9,  8'h5A, 8'h05, 1'b0, 1'b1, 1'b1, 1'b1},  // R4 message
        '{3'd7, 5'd31, 8'h1F, 8'hE3, 1'b0, 1'b1, 1'b1, 1'b0},  // R3 R8 last stream/channel
        '{3'd0, 5'd2,  8'h00, 8'h02, 1'b0, 1'b1, 1'b0, 1'b0},  // R7 disabled, R8 ctl
        '{3'd4, 5'd17, 8'hC3, 8'h40, 1'b1, 1'b1, 1'b1, 1'b1},  // R5 global message
        '{3'd5, 5'd20, 8'h11, 8'h05, 1'b0, 1'b0, 1'b0, 1'b1},  // R6 drive enable low
        '{3'd6, 5'd10, 8'h9C, 8'h21, 1'b0, 1'b1, 1'b1, 1'b0},  // R3 from in 1 ch 28
        '{3'd3, 5'd2,  8'h3C, 8'h07, 1'b1, 1'b0, 1'b0, 1'b1}   // R6 overrides R5
    };

    function automatic logic [7:0] pat(input int f, input int s, input int c);
        return 8'((f * 29 + s * 37 + c * 11 + 5) & 255);
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [7:0] got, input logic [7:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: got %02h expected %02h", req, what, got, exp);
        end
    endtask

    // One frame; writes the low byte at position 0 and the high byte at position 1.
    task automatic run_frame(input int f, input bit do_w, input logic [7:0] a,
                             input logic [7:0] lo, input logic [7:0] hi,
                             input int cs, input int cc, input bit exp_oe,
                             input logic [7:0] exp_byte, input bit exp_ctl,
                             input string req);
        logic [7:0] got_byte = '0;
        logic [7:0] got_oe   = '0;
        logic       got_ctl  = 1'b0;
        for (int p = 0; p < 256; p++) begin
            @(negedge clk);
            fsync_i = (p == 0);
            for (int s = 0; s < 8; s++) begin
                logic [7:0] b;
                b = pat(f, s, p / 8);
                ser_in[s] = b[7 - (p % 8)];
            end
            cfg_we    = do_w && (p < 2);
            cfg_hi    = (p == 1);
            cfg_addr  = a;
            cfg_wdata = (p == 1) ? hi : lo;
            @(posedge clk);
            #1;
            if (cs >= 0 && (p / 8) == cc) begin
                got_byte[7 - (p % 8)] = ser_out[cs];
                got_oe[7 - (p % 8)]   = ser_oe[cs];
            end
            if (cs >= 0 && p == ((cc + 31) % 32) * 8 + cs)
                got_ctl = ctl_out;
        end
        if (cs >= 0) begin
            check(got_byte == exp_byte, req, "slot data", got_byte, exp_byte);
            check(got_oe == {8{exp_oe}}, req, "slot drive enable", got_oe, {8{exp_oe}});
            check(got_ctl == exp_ctl, "R8", "control stream bit", 8'(got_ctl), 8'(exp_ctl));
        end
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int f;
        logic [7:0] exp_b;
        logic [7:0] qoe;
        logic [7:0] qout;
        logic       qctl;

        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: state right after reset
        check(ser_oe == 8'h00, "R1", "ser_oe after reset", ser_oe, 8'h00);
        check(ser_out == 8'h00 && ctl_out == 1'b0, "R1", "ser_out/ctl after reset",
              ser_out, 8'h00);

        // R2: no frame pulse yet, global enables on
        msg_all_i = 1'b1;
        ode_i     = 1'b1;
        qoe = '0; qout = '0; qctl = 1'b0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            qoe  |= ser_oe;
            qout |= ser_out;
            qctl |= ctl_out;
        end
        check(qoe == 8'h00, "R2", "ser_oe before frame pulse", qoe, 8'h00);
        check(qout == 8'h00 && qctl == 1'b0, "R2", "ser_out/ctl before frame pulse",
              qout, 8'h00);
        msg_all_i = 1'b0;

        // warm-up frame fills the data store
        run_frame(0, 0, 8'h00, 8'h00, 8'h00, -1, 0, 0, 8'h00, 0, "R9");

        // vector table: R3 R4 R5 R6 R7 R8 with R9 sample timing
        f = 1;
        for (int v = 0; v < NV; v++) begin
            vec_t t;
            bit   oe_e;
            t = VECS[v];
            @(negedge clk);
            msg_all_i = t.me;
            ode_i     = t.ode;
            oe_e = t.ode && (t.me || t.hi[0]);
            check(oe_e == t.exp_oe, "R7", "vector table consistency", 8'(oe_e), 8'(t.exp_oe));
            if (!t.exp_oe)       exp_b = 8'h00;
            else if (t.exp_msg)  exp_b = t.lo;
            else                 exp_b = pat(f - 1, int'(t.hi[7:5]), int'(t.lo[4:0]));
            run_frame(f, 1, {t.s, t.c}, t.lo, t.hi, int'(t.s), int'(t.c),
                      t.exp_oe, exp_b, t.hi[1],
                      t.exp_msg ? (t.me ? "R5" : "R4") : (t.ode ? "R3 R9" : "R6"));
            f++;
        end

        // R1: reset in mid-frame silences outputs at once and clears connection words
        msg_all_i = 1'b0;
        ode_i     = 1'b1;
        for (int i = 0; i < 50; i++) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(ser_oe == 8'h00 && ctl_out == 1'b0, "R1", "ser_oe after mid-frame reset",
              ser_oe, 8'h00);
        run_frame(f, 0, 8'h00, 8'h00, 8'h00, -1, 0, 0, 8'h00, 0, "R1");
        f++;
        // slot (1,4) was driving before reset; it must now be off
        run_frame(f, 0, 8'h00, 8'h00, 8'h00, 1, 4, 0, 8'h00, 0, "R1");
        f++;
        // slot (7,31) control bit cleared too (R1, R8)
        run_frame(f, 0, 8'h00, 8'h00, 8'h00, 7, 31, 0, 8'h00, 0, "R1");

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule